// File: doc/BRIEF.md
# Serial Command Register Interface

This block is the configuration port of a multi-channel readout chip. A host sends fixed 16-bit commands one bit per clock over a single lane, marked by a valid qualifier and a start-of-command strobe. The block rebuilds each command and acts on it. It can load an 8-bit value into one of 64 configuration registers, stall intake for a fixed number of cycles, or raise a one-cycle frame-start pulse. The frame-start pulse asks the readout engine to snapshot and clear the counters, stream the results and begin a new frame. The contents of all 64 registers drive a flat parallel bus for the rest of the chip.

After reset, bit 0 of register 0 is set, which puts the block in an echo mode. In this mode each accepted command bit is copied to every output lane one cycle later. The host uses the echo to measure and trim its link delays. A control write clears the echo mode and returns the lanes to idle zero.

The command word uses these fields: bits [15:14] are the opcode, bits [13:8] are the register address and bits [7:0] are the data. Bit 15 is sent first.

Top module: `serial_cfg_port`

## Requirements
- R1: After reset, register 0 reads 8'h01 and registers 1 to 63 read zero. `cmd_ready` is 1, `frame_start` is 0 and `lane_out` is 0.
- R2: A bit is accepted when `cmd_valid` and `cmd_ready` are both high. Accepted bits are gathered MSB first. The command is decoded on the clock edge that accepts the 16th bit. Opcode 2'b00 loads bits [7:0] into the register addressed by bits [13:8], and the new value is visible on `cfg_flat[8*a +: 8]` in the cycle after that edge.
- R3: Cycles with `cmd_valid` low do not advance the command, whatever `cmd_bit` carries.
- R4: When an accepted bit has `cmd_first` high, any partly received command is dropped and that bit becomes bit 15 of a new command.
- R5: Opcode 2'b01 (stall) drives `cmd_ready` low for exactly 20 cycles, starting in the cycle after decode. Bits offered during those cycles are not accepted and are not echoed. No register changes.
- R6: Opcode 2'b10 (frame start) raises `frame_start` for exactly one cycle. The pulse comes in the cycle after decode when `readout_busy` is low, and no register changes.
- R7: While `readout_busy` is high, `frame_start` stays low and the request is held. The request fires in the first cycle that `readout_busy` is low. Any number of frame-start commands received while one is held give a single pulse.
- R8: While bit 0 of register 0 is 1, every lane of `lane_out` shows the most recently accepted command bit, updated in the cycle after acceptance. While that bit is 0, `lane_out` is all zero.
- R9: Opcode 2'b11 (control write) loads bits [7:0] into register 0 with bit 0 forced to 0, whatever the address field holds. This leaves echo mode.
- R10: A write changes only the addressed register. All other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_bit | input | 1 | Serial command data |
| cmd_valid | input | 1 | Qualifies `cmd_bit` this cycle |
| cmd_first | input | 1 | Marks the bit as the first bit (bit 15) of a command |
| readout_busy | input | 1 | Readout engine busy; holds off `frame_start` |
| cmd_ready | output | 1 | Low while a stall is running |
| frame_start | output | 1 | One-cycle frame swap and readout request |
| lane_out | output | LANES | Echo lanes |
| cfg_flat | output | 512 | All 64 registers; register a sits at bits [8a+7:8a] |

## Verification
The assertions assume that `readout_busy` is a level driven by a well-behaved engine. They also assume that the stall command is the only source of a falling `cmd_ready`. Apart from that, nothing is required of the host: bits may arrive with gaps, during a stall or in the middle of a command. The stimulus drives every input half a cycle away from the sampling edge. It does break the framing on purpose, by sending bits during a stall and by sending a truncated command, and then checks that the port recovers. Every frame-start request is checked against a busy level that the bench holds steady across the expected pulse cycle.

// File: rtl/cmdif_pkg.sv
package cmdif_pkg;
  localparam int CMD_W  = 16;
  localparam int DATA_W = 8;
  localparam int NREG   = 64;
  localparam int ADDR_W = $clog2(NREG);
  localparam int CNT_W  = $clog2(CMD_W);
  localparam logic [DATA_W-1:0] REG0_INIT = 8'h01;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b00,
    OP_STALL = 2'b01,
    OP_FRAME = 2'b10,
    OP_CTRL  = 2'b11
  } op_e;

  function automatic op_e cmd_op(input logic [CMD_W-1:0] w);
    return op_e'(w[CMD_W-1 -: 2]);
  endfunction

  function automatic logic [ADDR_W-1:0] cmd_addr(input logic [CMD_W-1:0] w);
    return w[DATA_W +: ADDR_W];
  endfunction

  function automatic logic [DATA_W-1:0] cmd_data(input logic [CMD_W-1:0] w);
    return w[DATA_W-1:0];
  endfunction

  // control write: same data with the echo-enable bit cleared
  function automatic logic [DATA_W-1:0] ctrl_value(input logic [DATA_W-1:0] d);
    return d & ~{{(DATA_W-1){1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/cmd_shifter.sv
module cmd_shifter
  import cmdif_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_in,
  input  logic             accept,
  input  logic             first,
  output logic             word_done,
  output logic [CMD_W-1:0] word
);
  logic [CMD_W-2:0] sh_q;
  logic [CNT_W-1:0] cnt_q;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CMD_W - 1);

  assign word      = {sh_q, bit_in};
  assign word_done = accept && !first && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (accept) begin
      sh_q <= {sh_q[CMD_W-3:0], bit_in};
      if (first)          cnt_q <= CNT_W'(1);
      else if (word_done) cnt_q <= '0;
      else                cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R2
  bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(cnt_q));
  // R4
  first_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && first) |=> (cnt_q == CNT_W'(1)));
endmodule

// File: rtl/stall_timer.sv
module stall_timer #(
  parameter int CYCLES = 20
)(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic ready
);
  localparam int TW = $clog2(CYCLES + 1);
  logic [TW-1:0] cnt_q;

  assign ready = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (start)      cnt_q <= TW'(CYCLES);
    else if (cnt_q != 0) cnt_q <= cnt_q - TW'(1);
  end

  // R5
  stall_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(start));
  // R5
  stall_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !ready);
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cmdif_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [ADDR_W-1:0]      waddr,
  input  logic [DATA_W-1:0]      wdata,
  output logic [NREG*DATA_W-1:0] flat
);
  logic [NREG-1:0] sel;

  for (genvar a = 0; a < NREG; a++) begin : g_reg
    localparam logic [DATA_W-1:0] INIT = (a == 0) ? REG0_INIT : '0;
    logic [DATA_W-1:0] q;
    assign sel[a] = we && (waddr == ADDR_W'(a));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= INIT;
      else if (sel[a]) q <= wdata;
    end
    assign flat[a*DATA_W +: DATA_W] = q;
  end

  // R10
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(flat));
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
  import cmdif_pkg::*;
#(
  parameter int STALL_CYCLES = 20,
  parameter int LANES        = 2
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_bit,
  input  logic                   cmd_valid,
  input  logic                   cmd_first,
  input  logic                   readout_busy,
  output logic                   cmd_ready,
  output logic                   frame_start,
  output logic [LANES-1:0]       lane_out,
  output logic [NREG*DATA_W-1:0] cfg_flat
);
  logic             accept, word_done;
  logic [CMD_W-1:0] word;
  op_e              op;
  logic             wr_dec, ctl_dec, stall_dec, frame_dec;
  logic             reg_we;
  logic [ADDR_W-1:0] reg_addr;
  logic [DATA_W-1:0] reg_data;
  logic             echo_q, pend_q, echo_en;

  assign accept = cmd_valid && cmd_ready;

  cmd_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .bit_in(cmd_bit), .accept(accept),
    .first(cmd_first), .word_done(word_done), .word(word)
  );

  assign op        = cmd_op(word);
  assign wr_dec    = word_done && (op == OP_WRITE);
  assign ctl_dec   = word_done && (op == OP_CTRL);
  assign stall_dec = word_done && (op == OP_STALL);
  assign frame_dec = word_done && (op == OP_FRAME);

  assign reg_we   = wr_dec || ctl_dec;
  assign reg_addr = ctl_dec ? '0 : cmd_addr(word);
  assign reg_data = ctl_dec ? ctrl_value(cmd_data(word)) : cmd_data(word);

  stall_timer #(.CYCLES(STALL_CYCLES)) u_stall (
    .clk(clk), .rst_n(rst_n), .start(stall_dec), .ready(cmd_ready)
  );

  cfg_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(reg_addr),
    .wdata(reg_data), .flat(cfg_flat)
  );

  assign echo_en  = cfg_flat[0];
  assign lane_out = echo_en ? {LANES{echo_q}} : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      echo_q <= 1'b0;
    else if (accept) echo_q <= cmd_bit;
  end

  assign frame_start = pend_q && !readout_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= frame_dec || (pend_q && !frame_start);
  end

  // R6
  frame_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
  // R7
  frame_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> ($past(frame_dec) || $past(readout_busy)));
  // R9
  ctrl_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_dec |=> (lane_out == '0));
  // R8
  echo_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && echo_en && !reg_we) |=> (lane_out == {LANES{$past(cmd_bit)}}));
endmodule

// File: tb/sim_serial_cfg_port.sv
module sim_serial_cfg_port;
  logic clk = 0, rst_n = 0;
  logic cmd_bit = 0, cmd_valid = 0, cmd_first = 0, readout_busy = 0;
  logic cmd_ready, frame_start;
  logic [1:0] lane_out;
  logic [511:0] cfg_flat;
  int checks = 0, errors = 0;
  logic [7:0] model [64];

  always #10 clk = ~clk;

  serial_cfg_port u0 (
    .clk(clk), .rst_n(rst_n), .cmd_bit(cmd_bit), .cmd_valid(cmd_valid),
    .cmd_first(cmd_first), .readout_busy(readout_busy), .cmd_ready(cmd_ready),
    .frame_start(frame_start), .lane_out(lane_out), .cfg_flat(cfg_flat)
  );

  function automatic logic [511:0] flat_model();
    logic [511:0] f;
    for (int a = 0; a < 64; a++) f[a*8 +: 8] = model[a];
    return f;
  endfunction

  function automatic logic [15:0] mk(input logic [1:0] op, input int a, input int d);
    return {op, 6'(a), 8'(d)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_regs(input string tag);
    chk(cfg_flat == flat_model(), tag, cfg_flat, flat_model());
  endtask

  // sends a word; gap idle cycles between bits with junk on cmd_bit
  task automatic send(input logic [15:0] w, input int gap, input bit lane_chk);
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk);
      if (lane_chk && i < 15) begin
        logic [1:0] e = model[0][0] ? {2{w[i+1]}} : 2'b00;
        chk(lane_out == e, "R8 echo", 512'(lane_out), 512'(e));
      end
      cmd_valid = 1; cmd_bit = w[i]; cmd_first = (i == 15);
      if (i > 0) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          cmd_valid = 0; cmd_bit = ~cmd_bit; cmd_first = 0;
        end
      end
    end
    @(negedge clk);
    cmd_valid = 0; cmd_first = 0; cmd_bit = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int a = 0; a < 64; a++) model[a] = 8'h00;
    model[0] = 8'h01;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check_regs("R1 reset regs");
    chk(cmd_ready == 1 && frame_start == 0 && lane_out == 0, "R1 reset outs",
        512'({cmd_ready, frame_start, lane_out}), 512'(4'b1000));

    // R2 R10 R8: exhaustive address sweep, echo mode kept on
    for (int a = 0; a < 64; a++) begin
      int d = (a * 37 + 91) & 255;
      if (a == 0) d = d | 1;
      send(mk(2'b00, a, d), 0, 1);
      model[a] = 8'(d);
      check_regs("R2/R10 write sweep");
    end

    // R3: gapped bits with junk while invalid
    send(mk(2'b00, 9, 8'h5C), 2, 0);
    model[9] = 8'h5C;
    check_regs("R3 gapped write");

    // R4: truncated command then a fresh one marked first
    for (int i = 0; i < 7; i++) begin
      @(negedge clk); cmd_valid = 1; cmd_bit = 1; cmd_first = (i == 0);
    end
    send(mk(2'b00, 17, 8'hC3), 0, 0);
    model[17] = 8'hC3;
    check_regs("R4 restart on first");

    // R5: stall length, ignored bits, no echo
    begin
      int n = 0;
      logic [15:0] w = mk(2'b01, 33, 8'hFF);
      send(w, 0, 0);
      while (!cmd_ready && n < 100) begin
        n++;
        cmd_valid = 1; cmd_bit = n[0]; cmd_first = 0;
        @(negedge clk);
      end
      cmd_valid = 0;
      chk(n == 20, "R5 stall length", 512'(n), 512'(20));
      chk(lane_out == {2{w[0]}}, "R5 no echo during stall", 512'(lane_out), 512'({2{w[0]}}));
      check_regs("R5 stall leaves regs");
      send(mk(2'b00, 40, 8'h77), 0, 0);
      model[40] = 8'h77;
      check_regs("R5 write after stall");
    end

    // R6: immediate pulse
    send(mk(2'b10, 3, 8'h12), 0, 0);
    chk(frame_start == 1, "R6 pulse high", 512'(frame_start), 512'(1));
    @(negedge clk);
    chk(frame_start == 0, "R6 pulse one cycle", 512'(frame_start), 512'(0));
    check_regs("R6 regs unchanged");

    // R7: held by busy, merged requests
    readout_busy = 1;
    send(mk(2'b10, 0, 0), 0, 0);
    for (int k = 0; k < 4; k++) begin
      chk(frame_start == 0, "R7 held while busy", 512'(frame_start), 512'(0));
      @(negedge clk);
    end
    send(mk(2'b10, 1, 1), 0, 0);
    chk(frame_start == 0, "R7 held while busy", 512'(frame_start), 512'(0));
    readout_busy = 0;
    #1;
    chk(frame_start == 1, "R7 fires on release", 512'(frame_start), 512'(1));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(frame_start == 0, "R7 single pulse", 512'(frame_start), 512'(0));
    end

    // R9: control write ignores address, clears echo bit
    send(mk(2'b11, 5, 8'hA7), 0, 0);
    model[0] = 8'hA6;
    check_regs("R9 control write");
    send(mk(2'b00, 12, 8'hFF), 0, 1);
    model[12] = 8'hFF;
    chk(lane_out == 2'b00, "R8 lanes idle", 512'(lane_out), 512'(0));

    // R8: echo re-enabled via register 0 write
    send(mk(2'b00, 0, 8'h01), 0, 1);
    model[0] = 8'h01;
    send(mk(2'b00, 63, 8'h5A), 0, 1);
    model[63] = 8'h5A;
    check_regs("R8 re-enable");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule